// File: doc/BRIEF.md
# Programmable Interval Timer with Free-Running Divider

The block is a byte-wide bus peripheral that counts time for an 8-bit processor. A single 16-bit prescaler advances on every system clock. Its upper byte is exposed as a free-running divider. An 8-bit tick counter advances at one of four rates taken from the same prescaler. When the tick counter passes 0xFF it is loaded from a reload register and emits a one-clock interrupt request. A clearing flag elsewhere in the system turns that pulse into a latched request.

Software reaches four byte registers through an address, a write strobe, write data and combinational read data. The counter's run/stop behaviour is a two-state machine. In `ST_HALT` the counter holds its value. In `ST_RUN` it advances on each selected tick. The transition `HALT->RUN` is taken on a control write with bit 2 set, and `RUN->HALT` on a control write with bit 2 clear. Any other cycle keeps the current state. A double-speed input makes the prescaler step by two each clock, so every rate doubles.

Top module: `tick_timer`

## Requirements
- R1: After reset the divider, tick counter and reload register read 0x00, the control register reads 0xF8, the state is ST_HALT and the interrupt output is low.
- R2: Register offsets are 0x04 divider, 0x05 tick counter, 0x06 reload value, 0x07 control. Any other address reads 0xFF, and a write to it changes no register.
- R3: The divider is the upper byte of a 16-bit prescaler that advances by 1 per clock, or by 2 when the double-speed input is high. The divider therefore steps every 256 clocks, or every 128 in double speed.
- R4: A write of any data to offset 0x04 clears the whole prescaler to zero on that edge. The written data is discarded.
- R5: Control bits 1:0 select the tick rate. 00 gives one tick per 1024 prescaler counts, 01 gives one per 16, 10 gives one per 64 and 11 gives one per 256. A tick is the prescaler carrying into bit 10, 4, 6 or 8 respectively.
- R6: A tick in ST_RUN while the counter is 0xFF loads the reload register's present value and raises the interrupt output for exactly that one clock. Otherwise a tick in ST_RUN increments the counter.
- R7: Control bits 7:3 always read as 1. Bit 2 reads 1 in ST_RUN. Bits 1:0 read back the stored select.
- R8: A bus write to the tick counter on the same edge as a tick wins. The counter takes the written byte and no interrupt is raised on that edge.
- R9: In ST_HALT the tick counter holds its value and no interrupt is raised, while the prescaler and divider keep advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbl_speed | input | 1 | High doubles the prescaler step |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, one byte per clock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| timer_irq | output | 1 | One-clock interrupt request on counter reload |

## Verification
All four rate selects are swept at both prescaler step sizes. Each sweep starts with the counter just below overflow, which separates the four divisors and the reordered select coding. The same sweep also confirms that the reload takes the reload register rather than zero. The divider is read across long stretches and just after a write of non-zero data, which separates a true clear from a load of the written value. Two dedicated patterns isolate the corner rules. The first rewrites the counter to 0xFF on every clock at the fastest rate, so a write that does not beat a coinciding tick, or that lets the interrupt escape, becomes visible. The second runs a long stopped stretch, which separates halting the counter from halting the prescaler.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W = 8;
    localparam int PRE_W  = 16;

    localparam logic [7:0] OFS_DIV = 8'h04;
    localparam logic [7:0] OFS_CNT = 8'h05;
    localparam logic [7:0] OFS_MOD = 8'h06;
    localparam logic [7:0] OFS_CTL = 8'h07;

    localparam int CTL_RUN_BIT = 2;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // prescaler bit whose carry-in forms the tick for each rate select
    function automatic int rate_shift(input logic [1:0] sel);
        case (sel)
            2'b00:   return 10;
            2'b01:   return 4;
            2'b10:   return 6;
            default: return 8;
        endcase
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PW = PRE_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          dbl_i,
    input  logic [1:0]    sel_i,
    output logic [DW-1:0] div_o,
    output logic          tick_o
);
    logic [PW-1:0] pre_q;
    logic [PW-1:0] step;
    logic [3:0]    tick_vec;

    assign step = dbl_i ? PW'(2) : PW'(1);

    // one carry detector per rate select; step of 1 or 2 only
    for (genvar g = 0; g < 4; g++) begin : g_rate
        localparam int K = rate_shift(2'(g));
        assign tick_vec[g] = (&pre_q[K-1:1]) & (pre_q[0] | dbl_i);
    end

    assign tick_o = tick_vec[sel_i];
    assign div_o  = pre_q[PW-1 -: DW];

    always_ff @(posedge clk) begin
        if (!rst_n)     pre_q <= '0;
        else if (clr_i) pre_q <= '0;
        else            pre_q <= pre_q + step;
    end

    // R4
    pre_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pre_q == '0));

    // R3
    pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !dbl_i) |=> (pre_q[0] == ~$past(pre_q[0])));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          wr_cnt_i,
    input  logic          wr_mod_i,
    input  logic          wr_ctl_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] mod_o,
    output logic          run_o,
    output logic [1:0]    sel_o,
    output logic          irq_o
);
    run_state_e    st_q, st_d;
    logic [DW-1:0] cnt_q, mod_q;
    logic [1:0]    sel_q;
    logic          irq_q;
    logic          at_top;

    assign at_top = (cnt_q == {DW{1'b1}});

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT: if (wr_ctl_i && wdata_i[CTL_RUN_BIT])  st_d = ST_RUN;
            ST_RUN:  if (wr_ctl_i && !wdata_i[CTL_RUN_BIT]) st_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_HALT;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mod_q <= '0;
            sel_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (wr_cnt_i) begin
                cnt_q <= wdata_i;
            end else if (st_q == ST_RUN && tick_i) begin
                if (at_top) begin
                    cnt_q <= mod_q;
                    irq_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            if (wr_mod_i) mod_q <= wdata_i;
            if (wr_ctl_i) sel_q <= wdata_i[1:0];
        end
    end

    assign cnt_o = cnt_q;
    assign mod_o = mod_q;
    assign run_o = (st_q == ST_RUN);
    assign sel_o = sel_q;
    assign irq_o = irq_q;

    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    // R6
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (cnt_q == $past(mod_q)));

    // R8
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_i |=> (cnt_q == $past(wdata_i) && !irq_q));

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT && !wr_cnt_i) |=> ($stable(cnt_q) && !irq_q));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbl_speed,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              timer_irq
);
    logic              hit_div, hit_cnt, hit_mod, hit_ctl;
    logic [DATA_W-1:0] div_v, cnt_v, mod_v;
    logic [1:0]        sel_v;
    logic              run_v, tick_v;

    assign hit_div = (bus_addr == ADDR_W'(OFS_DIV));
    assign hit_cnt = (bus_addr == ADDR_W'(OFS_CNT));
    assign hit_mod = (bus_addr == ADDR_W'(OFS_MOD));
    assign hit_ctl = (bus_addr == ADDR_W'(OFS_CTL));

    tmr_prescaler #(.PW(PRE_W), .DW(DATA_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (bus_we && hit_div),
        .dbl_i  (dbl_speed),
        .sel_i  (sel_v),
        .div_o  (div_v),
        .tick_o (tick_v)
    );

    tmr_counter #(.DW(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_v),
        .wr_cnt_i (bus_we && hit_cnt),
        .wr_mod_i (bus_we && hit_mod),
        .wr_ctl_i (bus_we && hit_ctl),
        .wdata_i  (bus_wdata),
        .cnt_o    (cnt_v),
        .mod_o    (mod_v),
        .run_o    (run_v),
        .sel_o    (sel_v),
        .irq_o    (timer_irq)
    );

    always_comb begin
        bus_rdata = '1;
        if (hit_div)      bus_rdata = div_v;
        else if (hit_cnt) bus_rdata = cnt_v;
        else if (hit_mod) bus_rdata = mod_v;
        else if (hit_ctl) bus_rdata = {{(DATA_W-3){1'b1}}, run_v, sel_v};
    end

    // R7
    ctl_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ctl |-> (bus_rdata[DATA_W-1:3] == '1));
endmodule

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dbl = 1'b0;
    logic [7:0] addr = 8'h00;
    logic       we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [15:0] m_pre = '0;
    logic [7:0]  m_cnt = '0, m_mod = '0;
    logic [2:0]  m_ctl = '0;
    logic        m_irq = 1'b0;

    always #2.5 clk = ~clk;

    tick_timer u0 (
        .clk(clk), .rst_n(rst_n), .dbl_speed(dbl), .bus_addr(addr),
        .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata), .timer_irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [7:0] a);
        case (a)
            8'h04:   return m_pre[15:8];
            8'h05:   return m_cnt;
            8'h06:   return m_mod;
            8'h07:   return {5'h1F, m_ctl};
            default: return 8'hFF;
        endcase
    endfunction

    // arithmetic model of one clock edge, inputs as sampled at that edge
    task automatic model(input logic [7:0] a, input bit w, input logic [7:0] d);
        int per;
        logic [15:0] nxt;
        bit tick;
        case (m_ctl[1:0])
            2'b00: per = 1024;
            2'b01: per = 16;
            2'b10: per = 64;
            default: per = 256;
        endcase
        nxt  = m_pre + (dbl ? 16'd2 : 16'd1);
        tick = ((int'(nxt) % per) < (int'(m_pre) % per));
        m_irq = 1'b0;
        if (w && a == 8'h05) m_cnt = d;
        else if (m_ctl[2] && tick) begin
            if (m_cnt == 8'hFF) begin m_cnt = m_mod; m_irq = 1'b1; end
            else m_cnt = m_cnt + 8'd1;
        end
        if (w && a == 8'h06) m_mod = d;
        if (w && a == 8'h07) m_ctl = d[2:0];
        m_pre = (w && a == 8'h04) ? 16'd0 : nxt;
    endtask

    task automatic cyc(input logic [7:0] a, input bit w, input logic [7:0] d, input string tag);
        addr = a; we = w; wdata = d;
        @(posedge clk);
        model(a, w, d);
        @(negedge clk);
        we = 1'b0;
        check(tag, rdata, m_read(a));
        check({tag, " irq (R6)"}, {7'd0, irq}, {7'd0, m_irq});
    endtask

    initial begin
        addr = 8'h07;
        repeat (3) @(negedge clk);
        check("R1 ctl at reset", rdata, 8'hF8);
        check("R1 irq at reset", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        cyc(8'h04, 0, 8'h00, "R1 div");
        cyc(8'h05, 0, 8'h00, "R1 cnt");
        cyc(8'h06, 0, 8'h00, "R1 mod");
        cyc(8'h07, 0, 8'h00, "R1 ctl");

        // R2: unmapped address
        cyc(8'h10, 1, 8'h33, "R2 unmapped");
        cyc(8'h03, 0, 8'h00, "R2 unmapped read");
        cyc(8'h06, 0, 8'h00, "R2 mod untouched");
        cyc(8'h07, 0, 8'h00, "R2 ctl untouched");

        // R7: control readback
        cyc(8'h07, 1, 8'hFF, "R7 ctl all ones");
        cyc(8'h07, 1, 8'h02, "R7 ctl stop sel10");
        cyc(8'h07, 0, 8'h00, "R7 ctl read");

        // R3 R5 R6: sweep of speed and select
        for (int s = 0; s < 2; s++) begin
            dbl = logic'(s);
            for (int sel = 0; sel < 4; sel++) begin
                int per;
                per = (sel == 0) ? 1024 : (sel == 1) ? 16 : (sel == 2) ? 64 : 256;
                per = per >> s;
                cyc(8'h04, 1, 8'h5A, "R4 div clear");
                check("R4 div after write", rdata, 8'h00);
                cyc(8'h06, 1, 8'hA0 + 8'(sel), "R6 mod write");
                cyc(8'h05, 1, 8'hFD, "R6 cnt write");
                cyc(8'h07, 1, 8'h04 | 8'(sel), "R5 start");
                for (int i = 0; i < 4 * per + 20; i++) cyc(8'h05, 0, 8'h00, "R5 R6 cnt");
                for (int i = 0; i < 300; i++) cyc(8'h04, 0, 8'h00, "R3 div");
                cyc(8'h07, 1, 8'h00, "R9 stop");
            end
        end

        // R8: counter write coinciding with ticks at the fastest rate
        begin
            int irqs = 0;
            dbl = 1'b1;
            cyc(8'h07, 1, 8'h05, "R8 start");
            for (int i = 0; i < 64; i++) begin
                cyc(8'h05, 1, 8'hFF, "R8 cnt write");
                if (irq) irqs++;
            end
            check("R8 no irq while writing", 8'(irqs), 8'h00);
            check("R8 cnt holds write", rdata, 8'hFF);
        end

        // R9: stopped counter, running divider
        dbl = 1'b0;
        cyc(8'h07, 1, 8'h01, "R9 stop");
        cyc(8'h05, 1, 8'h42, "R9 cnt write");
        for (int i = 0; i < 1500; i++) cyc(8'h05, 0, 8'h00, "R9 cnt");
        check("R9 cnt held", rdata, 8'h42);
        cyc(8'h04, 0, 8'h00, "R9 div runs");
        check("R9 div advanced", 8'(rdata != 8'h00), 8'h01);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        end
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        end
        $finish;
    end
endmodule